// File: doc/BRIEF.md
# Exclusive Reservation Monitor

This block sits inside a memory-side AXI subordinate and lets managers carry out atomic read-modify-write without ever holding the interconnect. A manager reads a location with the lock bit set, which opens a reservation for that manager's ID. It then writes the same location with the lock bit set. The monitor decides in the subordinate whether that write may proceed. The write proceeds only if nothing has disturbed the reservation in the meantime.

The monitor observes accepted read and write address handshakes. It holds one reservation slot for each ID value. Each slot keeps an address, a transfer size and a valid flag. An accepted write address is held in a single pending register until the subordinate pulses the commit strobe. In that commit cycle the monitor drives the write response code and a suppress flag, with no added latency, so the memory can skip a failed exclusive write. The monitor never produces backpressure: it has no ready outputs.

Top module: `excl_monitor`

## Requirements
- R1: After reset no slot holds a reservation. A locked write committed before any locked read returns OKAY with suppress high.
- R2: A read accepted with the lock bit set makes its ID's slot hold that read's address and size. A later locked write from the same ID, with the same address and size and no intervening disturbance, returns EXOKAY with suppress low.
- R3: A locked write fails in three cases: its ID's slot is empty, the address differs, or the size differs. A failed write returns OKAY with suppress high and leaves every slot unchanged.
- R4: The response is 2'b01 for EXOKAY and 2'b00 for OKAY. It appears only in a cycle with wr_commit high. Outside such cycles bresp is 2'b00 and suppress is low.
- R5: A successful locked write clears its own ID's slot, so an identical repeat fails.
- R6: An unlocked write returns OKAY with suppress low. It clears every other ID's slot that it overlaps. It keeps its own ID's slot.
- R7: Two accesses overlap when their addresses agree after the low bits are cleared, using the larger of the two sizes (size s covers 2^s bytes). Writes that do not overlap leave other IDs' slots intact.
- R8: A successful locked write also clears the overlapping slots of other IDs.
- R9: A new locked read from an ID replaces that ID's earlier reservation.
- R10: Unlocked reads change no slot.
- R11: A write address is captured on aw_fire and judged on the next wr_commit. Slot updates take effect at the end of the commit cycle. A locked read in that same cycle sets its own slot after the write's clearing. A commit with no captured address returns OKAY with suppress low and changes nothing.
- R12: Each of the 2^ID_W IDs keeps its own slot independently of the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ar_fire | input | 1 | Read address accepted this cycle |
| ar_addr | input | ADDR_W | Read address |
| ar_id | input | ID_W | Read ID |
| ar_size | input | 3 | Read size, log2 bytes |
| ar_lock | input | 1 | Read is exclusive |
| aw_fire | input | 1 | Write address accepted this cycle |
| aw_addr | input | ADDR_W | Write address |
| aw_id | input | ID_W | Write ID |
| aw_size | input | 3 | Write size, log2 bytes |
| aw_lock | input | 1 | Write is exclusive |
| wr_commit | input | 1 | Captured write is being committed this cycle |
| bresp | output | 2 | Response code for the committed write |
| wr_suppress | output | 1 | Memory must not be updated by this write |

## Verification
The checker holds four properties on every cycle. Response and suppress stay quiet outside commit cycles. EXOKAY and suppress are never high together. An unlocked write always commits with OKAY and no suppress. A commit without a captured address is inert. The bench scenarios are the only place where the reservation bookkeeping itself becomes visible: setting, replacing and clearing slots, the overlap rule, independence between IDs, and the same-cycle read-versus-commit ordering. A reference model in the bench predicts every commit response across directed and random sequences.

// File: rtl/excl_monitor.sv
module excl_monitor #(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ar_fire,
  input  logic [ADDR_W-1:0] ar_addr,
  input  logic [ID_W-1:0]   ar_id,
  input  logic [2:0]        ar_size,
  input  logic              ar_lock,
  input  logic              aw_fire,
  input  logic [ADDR_W-1:0] aw_addr,
  input  logic [ID_W-1:0]   aw_id,
  input  logic [2:0]        aw_size,
  input  logic              aw_lock,
  input  logic              wr_commit,
  output logic [1:0]        bresp,
  output logic              wr_suppress
);
  localparam int SLOTS = 1 << ID_W;
  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_EXOKAY = 2'b01;

  logic              rv [SLOTS];
  logic [ADDR_W-1:0] ra [SLOTS];
  logic [2:0]        rs [SLOTS];

  logic              pv, pl;
  logic [ADDR_W-1:0] pa;
  logic [ID_W-1:0]   pi;
  logic [2:0]        ps;

  function automatic logic overlap(input logic [ADDR_W-1:0] a1, input logic [2:0] s1,
                                   input logic [ADDR_W-1:0] a2, input logic [2:0] s2);
    logic [2:0]        mx;
    logic [ADDR_W-1:0] mask;
    mx   = (s1 > s2) ? s1 : s2;
    mask = {ADDR_W{1'b1}} << mx;
    return ((a1 ^ a2) & mask) == '0;
  endfunction

  logic hit, commit_ok, excl_fail, writes_mem;

  assign hit        = rv[pi] && ra[pi] == pa && rs[pi] == ps;
  assign commit_ok  = wr_commit && pv;
  assign excl_fail  = pl && !hit;
  assign writes_mem = commit_ok && !excl_fail;

  assign bresp       = (commit_ok && pl && hit) ? RESP_EXOKAY : RESP_OKAY;
  assign wr_suppress = commit_ok && excl_fail;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pv <= 1'b0;
    end else begin
      if (wr_commit) pv <= 1'b0;
      if (aw_fire) begin
        pv <= 1'b1;
        pl <= aw_lock;
        pa <= aw_addr;
        pi <= aw_id;
        ps <= aw_size;
      end
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic own, kill;
    assign own  = pi == ID_W'(g);
    assign kill = writes_mem &&
                  ((pl && own) || (!own && overlap(ra[g], rs[g], pa, ps)));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rv[g] <= 1'b0;
      end else begin
        if (kill) rv[g] <= 1'b0;
        if (ar_fire && ar_lock && ar_id == ID_W'(g)) begin
          rv[g] <= 1'b1;
          ra[g] <= ar_addr;
          rs[g] <= ar_size;
        end
      end
    end
  end
endmodule

// File: rtl/excl_monitor_chk.sv
module excl_monitor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       aw_fire,
  input logic       aw_lock,
  input logic       wr_commit,
  input logic [1:0] bresp,
  input logic       wr_suppress
);
  logic seen_v, seen_lock;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_v    <= 1'b0;
      seen_lock <= 1'b0;
    end else begin
      if (wr_commit) seen_v <= 1'b0;
      if (aw_fire) begin
        seen_v    <= 1'b1;
        seen_lock <= aw_lock;
      end
    end
  end

  a_r4_quiet_outside_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_commit |-> (bresp == 2'b00 && !wr_suppress));

  a_r4_exokay_not_suppressed: assert property (@(posedge clk) disable iff (!rst_n)
    bresp == 2'b01 |-> !wr_suppress);

  a_r6_plain_write_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_commit && seen_v && !seen_lock) |-> (bresp == 2'b00 && !wr_suppress));

  a_r11_bare_commit_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_commit && !seen_v) |-> (bresp == 2'b00 && !wr_suppress));
endmodule

bind excl_monitor excl_monitor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .aw_fire(aw_fire), .aw_lock(aw_lock),
  .wr_commit(wr_commit), .bresp(bresp), .wr_suppress(wr_suppress)
);

// File: tb/excl_monitor_tb.sv
module excl_monitor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int IW = 2;
  localparam int NS = 1 << IW;

  logic clk = 0, rst_n = 0;
  logic ar_fire = 0, ar_lock = 0, aw_fire = 0, aw_lock = 0, wr_commit = 0;
  logic [AW-1:0] ar_addr = 0, aw_addr = 0;
  logic [IW-1:0] ar_id = 0, aw_id = 0;
  logic [2:0] ar_size = 0, aw_size = 0;
  logic [1:0] bresp;
  logic wr_suppress;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  bit          mv [NS];
  logic [AW-1:0] ma [NS];
  logic [2:0]  ms [NS];

  always #(CLK_PERIOD/2) clk = ~clk;

  excl_monitor #(.ADDR_W(AW), .ID_W(IW)) u_dut (.*);

  function automatic bit m_overlap(logic [AW-1:0] a, logic [2:0] s, logic [AW-1:0] b, logic [2:0] t);
    int m;
    m = (s > t) ? int'(s) : int'(t);
    return (a >> m) == (b >> m);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic rd(int id, logic [AW-1:0] a, logic [2:0] s, bit lk);
    @(negedge clk);
    ar_fire = 1; ar_id = IW'(id); ar_addr = a; ar_size = s; ar_lock = lk;
    @(negedge clk);
    ar_fire = 0; ar_lock = 0;
    if (lk) begin mv[id] = 1; ma[id] = a; ms[id] = s; end
    #1 check(bresp == 2'b00 && !wr_suppress, "R4", {bresp, wr_suppress}, 0);
  endtask

  // commit phase shared by writes; optional same-cycle locked read
  task automatic wr(int id, logic [AW-1:0] a, logic [2:0] s, bit lk, string req,
                    bit side_rd = 0, int rid = 0, logic [AW-1:0] ra = 0, logic [2:0] rsz = 0);
    bit hit, fail;
    @(negedge clk);
    aw_fire = 1; aw_id = IW'(id); aw_addr = a; aw_size = s; aw_lock = lk;
    @(negedge clk);
    aw_fire = 0; aw_lock = 0; wr_commit = 1;
    if (side_rd) begin
      ar_fire = 1; ar_lock = 1; ar_id = IW'(rid); ar_addr = ra; ar_size = rsz;
    end
    #1;
    hit  = mv[id] && ma[id] == a && ms[id] == s;
    fail = lk && !hit;
    check(bresp == ((lk && hit) ? 2'b01 : 2'b00), req, bresp, (lk && hit) ? 1 : 0);
    check(wr_suppress == fail, req, wr_suppress, fail);
    if (!fail)
      for (int k = 0; k < NS; k++)
        if ((k == id && lk) || (k != id && mv[k] && m_overlap(ma[k], ms[k], a, s))) mv[k] = 0;
    if (side_rd) begin mv[rid] = 1; ma[rid] = ra; ms[rid] = rsz; end
    @(negedge clk);
    wr_commit = 0; ar_fire = 0; ar_lock = 0;
  endtask

  task automatic bare_commit();
    @(negedge clk);
    wr_commit = 1;
    #1 check(bresp == 2'b00 && !wr_suppress, "R11", {bresp, wr_suppress}, 0);
    @(negedge clk);
    wr_commit = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      miscompares++; vectors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    for (int k = 0; k < NS; k++) mv[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1 check(bresp == 2'b00 && !wr_suppress, "R1", {bresp, wr_suppress}, 0);
    wr(0, 32'h100, 2, 1, "R1");                 // no reservation yet
    rd(0, 32'h100, 2, 1);
    wr(0, 32'h100, 2, 1, "R2");                 // EXOKAY
    wr(0, 32'h100, 2, 1, "R5");                 // cleared by success
    rd(1, 32'h200, 2, 1);
    wr(1, 32'h200, 1, 1, "R3");                 // size mismatch
    wr(1, 32'h200, 2, 1, "R3");                 // still intact -> EXOKAY
    rd(2, 32'h300, 3, 1);
    rd(2, 32'h340, 3, 1);
    wr(2, 32'h300, 3, 1, "R9");                 // replaced, fails
    wr(2, 32'h340, 3, 1, "R9");
    rd(3, 32'h400, 2, 1);
    rd(3, 32'h400, 0, 0);                       // plain read
    wr(3, 32'h400, 2, 1, "R10");
    rd(0, 32'h500, 2, 1);
    wr(1, 32'h504, 2, 0, "R7");                 // disjoint
    wr(0, 32'h500, 2, 1, "R7");
    rd(0, 32'h500, 2, 1);
    wr(1, 32'h504, 3, 0, "R6");                 // overlaps via larger size
    wr(0, 32'h500, 2, 1, "R6");
    rd(0, 32'h600, 2, 1);
    wr(0, 32'h600, 2, 0, "R6");                 // own plain write keeps slot
    wr(0, 32'h600, 2, 1, "R6");
    rd(0, 32'h700, 2, 1); rd(1, 32'h700, 2, 1);
    wr(1, 32'h700, 2, 1, "R8");
    wr(0, 32'h700, 2, 1, "R8");
    for (int k = 0; k < NS; k++) rd(k, 32'h800 + 32'(k*16), 2, 1);
    for (int k = NS-1; k >= 0; k--) wr(k, 32'h800 + 32'(k*16), 2, 1, "R12");
    rd(2, 32'h900, 2, 1);
    wr(2, 32'h900, 2, 1, "R11", 1, 2, 32'h900, 2); // success clears, read re-sets
    wr(2, 32'h900, 2, 1, "R11");
    bare_commit();
    for (int n = 0; n < 3000; n++) begin
      int id = $urandom_range(0, NS-1);
      logic [2:0] s = 3'($urandom_range(0, 3));
      logic [AW-1:0] a = (32'h1000 + 32'($urandom_range(0, 7) * 4)) & ~((32'd1 << s) - 1);
      bit lk = $urandom_range(0, 1) == 1;
      if ($urandom_range(0, 1) == 1) rd(id, a, s, lk);
      else wr(id, a, s, lk, "rand");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule